// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog

This block is a watchdog counter for a processor subsystem. Software controls it through one 32-bit control register. Each write to that register carries three fields: a 7-bit key, a command bit that starts or stops the counter, and a count field.

Once the watchdog is running, a write only takes effect when its key is the bitwise inverse of the key already stored. This makes a stray write very unlikely to restart or stop the counter.

The counter decrements once for each pulse on an external slow tick enable. Its expiry has two stages:

- **First expiry.** The block raises a non-maskable interrupt and loads a short grace count.
- **Second expiry.** If the grace count also runs out with no accepted write in between, the block issues a one-cycle system reset request and the counter stops.

A second, read-only status word reports the live count and the expiry stage.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, `nmiOut` is 0 and `resetReq` is 0.
- R2: The control word layout is: key in bits [15:9], run command in bit 8, count in bits [7:0]. A read at offset 0x40 returns the last accepted word unchanged.
- R3: While bit 8 of the stored control word is 0, a write to 0x40 is accepted whatever its key.
- R4: While bit 8 of the stored word is 1, a write whose key is not the bitwise inverse of the stored key is ignored entirely. The control word, count, stage and `nmiOut` all keep their values.
- R5: An accepted write reloads the counter from the count field. A count field of 0 loads 256.
- R6: The counter decreases by one on each clock edge with `tickEn` high, and only while running. When stopped it holds its value.
- R7: A tick that finds the count at 1 is an expiry. On the first expiry, `nmiOut` goes high in the next cycle, the stage becomes 1, and the count is loaded with `GRACE_TICKS` (default 1), which keeps running.
- R8: An expiry while the stage is 1 drives `resetReq` high for exactly one cycle. The counter then stops at 0, and `nmiOut` stays high.
- R9: An accepted write clears `nmiOut` and the stage. Reloading before expiry prevents the interrupt.
- R10: A read at offset 0x44 returns the count in bits [8:0] and the stage in bit 16, with all other bits 0. Writes to 0x44 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Slow count enable, one pulse per watchdog tick |
| busAddr | input | 8 | Register byte offset (0x40 control, 0x44 status) |
| busWrEn | input | 1 | Write strobe |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for `busAddr` (combinational) |
| nmiOut | output | 1 | Non-maskable interrupt, raised on the first expiry |
| resetReq | output | 1 | One-cycle system reset request on the second expiry |

## Verification
The bench drives several control-word patterns, and each one separates a different pair of behaviours:

- **Stopped write with a chosen key.** Checks that the stored word reads back and that ticks have no effect on a stopped counter.
- **Running write with a zero count.** Separates the 256 reload from a literal zero.
- **Wrong key while running, and a write to the status offset.** Both must leave every observable value unchanged, which distinguishes a rejected write from a reload.
- **Correctly inverted key.** The bench runs this write to full expiry to check the stage ordering: interrupt first, then the one-cycle reset pulse.
- **Inverted key mid-count.** The bench repeats the inverted-key write as a kick partway through the count. This confirms that a reload suppresses the interrupt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int KEY_W       = 7;
  localparam int KEY_LSB     = 9;
  localparam int CMD_BIT     = 8;
  localparam int CNT_FIELD_W = 8;
  localparam int CNT_W       = CNT_FIELD_W + 1;
  localparam int STAGE_BIT   = 16;
  localparam int WORD_W      = 32;

  typedef struct packed {
    logic             reload;
    logic             runCmd;
    logic [CNT_W-1:0] reloadVal;
    logic             grace;
    logic             halt;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int GRACE_TICKS = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  wdStrobe_t        strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             expire
);
  localparam logic [CNT_W-1:0] GraceVal = CNT_W'(GRACE_TICKS);
  localparam logic [CNT_W-1:0] One      = CNT_W'(1);

  assign expire = running && tickEn && (cnt == One);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (strobe.reload) begin
      cnt     <= strobe.reloadVal;
      running <= strobe.runCmd;
    end else if (strobe.grace) begin
      cnt     <= GraceVal;
    end else if (strobe.halt) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (running && tickEn) begin
      cnt     <= cnt - One;
    end
  end

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strobe.reload) |=> (cnt == $past(cnt))); // R6
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && cnt > One && !strobe.reload) |=> (cnt == $past(cnt) - One)); // R6
  AST_RELOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (cnt != '0)); // R5
endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
#(
  parameter logic [7:0] CTRL_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWData,
  input  logic              expire,
  output wdStrobe_t         strobe,
  output logic [WORD_W-1:0] ctrlWord,
  output logic              stage,
  output logic              nmiOut,
  output logic              resetReq
);
  logic ctrlWrite, keyOk, accept;
  logic [CNT_FIELD_W-1:0] cntField;

  assign ctrlWrite = busWrEn && (busAddr == CTRL_ADDR);
  assign keyOk     = busWData[KEY_LSB +: KEY_W] == ~ctrlWord[KEY_LSB +: KEY_W];
  assign accept    = ctrlWrite && (!ctrlWord[CMD_BIT] || keyOk);
  assign cntField  = busWData[CNT_FIELD_W-1:0];

  always_comb begin
    strobe.reload    = accept;
    strobe.runCmd    = busWData[CMD_BIT];
    strobe.reloadVal = (cntField == '0) ? CNT_W'(1 << CNT_FIELD_W) : CNT_W'(cntField);
    strobe.grace     = !accept && expire && !stage;
    strobe.halt      = !accept && expire && stage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      stage    <= 1'b0;
      nmiOut   <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= strobe.halt;
      if (accept) begin
        ctrlWord <= busWData;
        stage    <= 1'b0;
        nmiOut   <= 1'b0;
      end else if (strobe.grace) begin
        stage    <= 1'b1;
        nmiOut   <= 1'b1;
      end
    end
  end

  AST_RESET_AFTER_NMI: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> nmiOut); // R8
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R8
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && ctrlWord[CMD_BIT] && !keyOk) |=> $stable(ctrlWord)); // R4
  AST_ACCEPT_CLEARS_NMI: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (!nmiOut && !stage)); // R9
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int         GRACE_TICKS = 1,
  parameter logic [7:0] CTRL_ADDR   = 8'h40,
  parameter logic [7:0] STAT_ADDR   = 8'h44
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWData,
  output logic [31:0] busRData,
  output logic        nmiOut,
  output logic        resetReq
);
  wdStrobe_t         strobe;
  logic [CNT_W-1:0]  cnt;
  logic              running, expire, stage;
  logic [WORD_W-1:0] ctrlWord, statusWord;

  wdog_control #(.CTRL_ADDR(CTRL_ADDR)) i_control (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWData(busWData), .expire(expire), .strobe(strobe),
    .ctrlWord(ctrlWord), .stage(stage), .nmiOut(nmiOut), .resetReq(resetReq)
  );

  wdog_datapath #(.GRACE_TICKS(GRACE_TICKS)) i_datapath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .cnt(cnt), .running(running), .expire(expire)
  );

  always_comb begin
    statusWord            = '0;
    statusWord[CNT_W-1:0] = cnt;
    statusWord[STAGE_BIT] = stage;
    if (busAddr == CTRL_ADDR)      busRData = ctrlWord;
    else if (busAddr == STAT_ADDR) busRData = statusWord;
    else                           busRData = '0;
  end
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = 8'h40;
  logic        busWrEn = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        nmiOut, resetReq;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  localparam logic [7:0] CTRL = 8'h40, STAT = 8'h44;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWData(busWData), .busRData(busRData),
    .nmiOut(nmiOut), .resetReq(resetReq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] mkWord(logic [6:0] key, logic cmd, logic [7:0] c);
    return {16'h0, key, cmd, c};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readChk(string req, logic [7:0] a, logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, busRData, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic tReset();
    readChk("R1 ctrl", CTRL, 32'h0);
    readChk("R1 status", STAT, 32'h0);
    check("R1 nmi", {31'b0, nmiOut}, 32'h0);
    check("R1 resetReq", {31'b0, resetReq}, 32'h0);
  endtask

  task automatic tStoppedWrite();
    wr(CTRL, mkWord(7'h15, 1'b0, 8'd5));
    readChk("R2 readback", CTRL, mkWord(7'h15, 1'b0, 8'd5));
    readChk("R3 accepted when disabled", STAT, 32'd5);
    ticks(3);
    readChk("R6 stopped holds", STAT, 32'd5);
  endtask

  task automatic tZeroCount();
    wr(CTRL, mkWord(7'h2A, 1'b1, 8'd0));
    readChk("R5 zero loads 256", STAT, 32'd256);
    ticks(1);
    readChk("R6 one tick", STAT, 32'd255);
  endtask

  task automatic tBadKey();
    wr(CTRL, mkWord(7'h2A, 1'b0, 8'd9));
    readChk("R4 ctrl unchanged", CTRL, mkWord(7'h2A, 1'b1, 8'd0));
    readChk("R4 count unchanged", STAT, 32'd255);
    wr(STAT, mkWord(7'h55, 1'b1, 8'd3));
    readChk("R10 status write ignored", STAT, 32'd255);
    readChk("R10 ctrl untouched", CTRL, mkWord(7'h2A, 1'b1, 8'd0));
  endtask

  task automatic tExpire();
    wr(CTRL, mkWord(7'h55, 1'b1, 8'd3));
    readChk("R5 reload", STAT, 32'd3);
    ticks(2);
    readChk("R6 count at 1", STAT, 32'd1);
    check("R7 no nmi yet", {31'b0, nmiOut}, 32'h0);
    ticks(1);
    check("R7 nmi raised", {31'b0, nmiOut}, 32'h1);
    readChk("R7 grace loaded stage 1", STAT, 32'h0001_0001);
    check("R7 no reset yet", {31'b0, resetReq}, 32'h0);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    check("R8 reset pulse", {31'b0, resetReq}, 32'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, resetReq}, 32'h0);
    check("R8 nmi stays", {31'b0, nmiOut}, 32'h1);
    readChk("R8 counter stopped", STAT, 32'h0001_0000);
    ticks(2);
    readChk("R8 stays stopped", STAT, 32'h0001_0000);
  endtask

  task automatic tRecover();
    wr(CTRL, mkWord(7'h2A, 1'b1, 8'd4));
    check("R9 nmi cleared", {31'b0, nmiOut}, 32'h0);
    readChk("R9 stage cleared", STAT, 32'd4);
    ticks(2);
    wr(CTRL, mkWord(7'h55, 1'b1, 8'd4));
    readChk("R9 kick reloads", STAT, 32'd4);
    ticks(3);
    check("R9 kick prevents nmi", {31'b0, nmiOut}, 32'h0);
    readChk("R6 after kick", STAT, 32'd1);
    wr(CTRL, mkWord(7'h2A, 1'b0, 8'd7));
    ticks(2);
    readChk("R6 stop holds", STAT, 32'd7);
    check("R7 no expiry when stopped", {31'b0, nmiOut}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStoppedWrite();
    tZeroCount();
    tBadKey();
    tExpire();
    tRecover();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule